// File: doc/BRIEF.md
# Banked Program ROM Address Mapper

This block sits between a 16-bit CPU bus with byte addresses and two program ROMs that are 16 bits wide. The first ROM is fixed at the bottom of the address space. The second ROM is seen through a 1 MiB window, and a 2-bit bank register selects which 1 MiB part of it appears there. Software loads the bank register by writing to an odd byte address inside the window. Each access is decoded combinationally into one chip enable and a word address for the selected ROM. The bank value is also driven out on its own pins.

A static configuration pin marks the first ROM as a 16 Mbit device. In that mode the second ROM is never enabled, and the first ROM is split across both regions. The window shows the first half of the first ROM, and the bottom region shows its second half. The bank register still loads in this mode, but it has no effect on any ROM address.

The bus has no data stream, so it carries no valid/ready pair. Every pin is a plain level, and the block never stalls the CPU.

Top module: `prog_rom_mapper`

## Requirements
- R1: With `lo_rom_16m`=0, any byte address with bits [23:20]=0x0 (0x000000..0x0FFFFF) asserts only `rom0_ce`. In that case `rom0_addr` = {1'b0, cpu_addr[19:1]}.
- R2: With `lo_rom_16m`=0, any byte address with bits [23:20]=0x2 (0x200000..0x2FFFFF) asserts only `rom1_ce`. In that case `rom1_addr[18:0]` = cpu_addr[19:1], `rom1_addr[19]` = bank bit 0 and `rom1_addr[20]` = bank bit 1.
- R3: With `lo_rom_16m`=1, the window 0x2xxxxx asserts `rom0_ce` with `rom0_addr` = {1'b0, cpu_addr[19:1]}, and the region 0x0xxxxx asserts `rom0_ce` with `rom0_addr` = {1'b1, cpu_addr[19:1]}. `rom1_ce` is never asserted in this mode.
- R4: When address bits [23:20] are neither 0x0 nor 0x2, neither enable is asserted. A ROM whose enable is low sees an address of all zeros.
- R5: The bank register loads `cpu_wdata[1:0]` when a rising edge of `cpu_wr` is sampled by `clk` while `cpu_addr` is odd and inside 0x200000..0x2FFFFF. The new value appears on `bank` after the clock edge that samples the rising edge.
- R6: A write to an even address or to any address outside the window leaves `bank` unchanged. A `cpu_wr` that stays high loads the register only once, so a change of data while the strobe is held has no effect.
- R7: An active-low `rst_n` clears `bank` to 0 at once, and `bank` stays 0 while reset is held.
- R8: `rom0_ce` and `rom1_ce` are never high at the same time.
- R9: Bank writes load the register in 16 Mbit mode as well, and the bank value has no effect on `rom0_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wr | input | 1 | Write strobe, active high; a rising edge is a write |
| cpu_wdata | input | 2 | CPU data bits D1..D0 |
| lo_rom_16m | input | 1 | 1 = first ROM is a 16 Mbit device (split map) |
| rom0_ce | output | 1 | Enable of the first ROM |
| rom0_addr | output | 20 | Word address of the first ROM |
| rom1_ce | output | 1 | Enable of the second ROM |
| rom1_addr | output | 21 | Word address of the second ROM; the top two bits come from the bank |
| bank | output | 2 | Current bank register value |

## Verification
Assertions check on every cycle that the two enables are exclusive and that the second ROM is silent in 16 Mbit mode. They also check that unmapped addresses select no ROM and that the top address lines of the second ROM track the bank register. Inside the latch, assertions check that a qualified write edge loads the data and that anything else keeps the bank stable. The bench scenarios are needed for the rest. These cover the split-map placement of the two halves, the single load from a strobe held high, the rejection of even and out-of-window writes, and the bank being cleared by a reset in the middle of a run.

// File: rtl/prm_pkg.sv
package prm_pkg;
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_LOW    = 2'd1,
    REG_BANKED = 2'd2
  } region_e;
endpackage

// File: rtl/prm_region_dec.sv
module prm_region_dec
  import prm_pkg::*;
#(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned LOW_SEL  = 0,
  parameter int unsigned BANK_SEL = 2
) (
  input  logic [SEL_W-1:0] sel,
  output region_e          region
);
  always_comb begin
    if (sel == SEL_W'(LOW_SEL))       region = REG_LOW;
    else if (sel == SEL_W'(BANK_SEL)) region = REG_BANKED;
    else                              region = REG_NONE;
  end
endmodule

// File: rtl/prm_bank_latch.sv
module prm_bank_latch #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic              hit,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);
  logic wr_q;
  logic edge_seen;

  assign edge_seen = wr_strobe & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      bank <= '0;
    end else begin
      wr_q <= wr_strobe;
      if (edge_seen && hit) bank <= wdata;
    end
  end

  // R5: a fresh strobe edge on a qualified address captures the data
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !wr_q && hit) |=> (bank == $past(wdata)));

  // R6: without a qualified write the bank holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && hit) |=> $stable(bank));
endmodule

// File: rtl/prm_addr_former.sv
module prm_addr_former
  import prm_pkg::*;
#(
  parameter int unsigned WORD_W = 19,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned ROM0_AW = WORD_W + 1,
  localparam int unsigned ROM1_AW = WORD_W + BANK_W
) (
  input  region_e            region,
  input  logic               split_map,
  input  logic [WORD_W-1:0]  word,
  input  logic [BANK_W-1:0]  bank,
  output logic               rom0_ce,
  output logic [ROM0_AW-1:0] rom0_addr,
  output logic               rom1_ce,
  output logic [ROM1_AW-1:0] rom1_addr
);
  always_comb begin
    rom0_ce   = 1'b0;
    rom1_ce   = 1'b0;
    rom0_addr = '0;
    rom1_addr = '0;
    unique case (region)
      REG_LOW: begin
        rom0_ce   = 1'b1;
        rom0_addr = {split_map, word};
      end
      REG_BANKED: begin
        if (split_map) begin
          rom0_ce   = 1'b1;
          rom0_addr = {1'b0, word};
        end else begin
          rom1_ce   = 1'b1;
          rom1_addr = {bank, word};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prog_rom_mapper.sv
module prog_rom_mapper
  import prm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned OFFS_W   = 20,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned LOW_SEL  = 0,
  parameter int unsigned BANK_SEL = 2,
  localparam int unsigned SEL_W   = ADDR_W - OFFS_W,
  localparam int unsigned WORD_W  = OFFS_W - 1,
  localparam int unsigned ROM0_AW = WORD_W + 1,
  localparam int unsigned ROM1_AW = WORD_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_wr,
  input  logic [BANK_W-1:0]  cpu_wdata,
  input  logic               lo_rom_16m,
  output logic               rom0_ce,
  output logic [ROM0_AW-1:0] rom0_addr,
  output logic               rom1_ce,
  output logic [ROM1_AW-1:0] rom1_addr,
  output logic [BANK_W-1:0]  bank
);
  region_e region;
  logic    bank_hit;

  prm_region_dec #(.SEL_W(SEL_W), .LOW_SEL(LOW_SEL), .BANK_SEL(BANK_SEL)) u_dec (
    .sel    (cpu_addr[ADDR_W-1:OFFS_W]),
    .region (region)
  );

  assign bank_hit = (region == REG_BANKED) && cpu_addr[0];

  prm_bank_latch #(.BANK_W(BANK_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (cpu_wr),
    .hit       (bank_hit),
    .wdata     (cpu_wdata),
    .bank      (bank)
  );

  prm_addr_former #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_form (
    .region    (region),
    .split_map (lo_rom_16m),
    .word      (cpu_addr[OFFS_W-1:1]),
    .bank      (bank),
    .rom0_ce   (rom0_ce),
    .rom0_addr (rom0_addr),
    .rom1_ce   (rom1_ce),
    .rom1_addr (rom1_addr)
  );

  // R8: never two ROMs on one access
  a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom0_ce && rom1_ce));

  // R3: split map keeps the second ROM idle
  a_r3_no_rom1: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rom_16m |-> !rom1_ce);

  // R4: unmapped addresses select nothing
  a_r4_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_addr[ADDR_W-1:OFFS_W] != SEL_W'(LOW_SEL)) &&
     (cpu_addr[ADDR_W-1:OFFS_W] != SEL_W'(BANK_SEL))) |-> (!rom0_ce && !rom1_ce));

  // R2: the upper lines of the banked ROM follow the bank register
  a_r2_bank_lines: assert property (@(posedge clk) disable iff (!rst_n)
    rom1_ce |-> (rom1_addr[ROM1_AW-1 -: BANK_W] == bank));
endmodule

// File: tb/test_prog_rom_mapper.sv
module test_prog_rom_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_wdata = '0;
  logic        lo_rom_16m = 1'b0;
  logic        rom0_ce, rom1_ce;
  logic [19:0] rom0_addr;
  logic [20:0] rom1_addr;
  logic [1:0]  bank;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit live = 0;

  always #10 clk = ~clk;

  prog_rom_mapper i_prog_rom_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .lo_rom_16m(lo_rom_16m),
    .rom0_ce(rom0_ce), .rom0_addr(rom0_addr), .rom1_ce(rom1_ce),
    .rom1_addr(rom1_addr), .bank(bank)
  );

  // reference bank state
  int m_bank;
  bit m_prev_wr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank    <= 0;
      m_prev_wr <= 0;
    end else begin
      m_prev_wr <= cpu_wr;
      if (cpu_wr && !m_prev_wr && (int'(cpu_addr) % 2 == 1) &&
          (int'(cpu_addr) / 'h100000 == 2))
        m_bank <= int'(cpu_wdata);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference map
  always @(negedge clk) begin
    if (live && rst_n) begin
      int a, hi, w, e0, e1, a0, a1;
      string tag;
      a = int'(cpu_addr); hi = a / 'h100000; w = (a % 'h100000) / 2;
      e0 = 0; e1 = 0; a0 = 0; a1 = 0;
      if (hi == 0) begin
        e0 = 1; a0 = lo_rom_16m ? ('h80000 + w) : w;
        tag = lo_rom_16m ? "R3" : "R1";
      end else if (hi == 2) begin
        if (lo_rom_16m) begin e0 = 1; a0 = w; tag = "R3"; end
        else begin e1 = 1; a1 = m_bank * 'h80000 + w; tag = "R2"; end
      end else tag = "R4";
      chk({tag, " rom0_ce"}, int'(rom0_ce), e0);
      chk({tag, " rom1_ce"}, int'(rom1_ce), e1);
      chk({tag, " rom0_addr"}, int'(rom0_addr), a0);
      chk({tag, " rom1_addr"}, int'(rom1_addr), a1);
      chk("R5 bank", int'(bank), m_bank);
      chk("R8 exclusive", int'(rom0_ce && rom1_ce), 0);
    end
  end

  task automatic drive(int addr, bit wr, int wd);
    @(posedge clk); #3;
    cpu_addr = 24'(addr); cpu_wr = wr; cpu_wdata = 2'(wd);
  endtask

  task automatic bus_write(int addr, int wd);
    drive(addr, 0, wd);
    drive(addr, 1, wd);
    drive(addr, 0, wd);
  endtask

  task automatic chk_bank_now(string tag, int exp);
    @(negedge clk);
    chk(tag, int'(bank), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    int probe [8] = '{'h000000, 'h000002, 'h0FFFFE, 'h054321,
                      'h200000, 'h2FFFFF, 'h2ABCDE, 'h212345};
    int outside [5] = '{'h100000, 'h1FFFFF, 'h300000, 'h400001, 'hFFFFFE};
    // R7: reset state
    repeat (3) @(posedge clk);
    chk_bank_now("R7 bank in reset", 0);
    #3 rst_n = 1'b1;
    live = 1;
    // R1 / R2: normal map with bank 0
    foreach (probe[i]) drive(probe[i], 0, 0);
    // R4: unmapped regions
    foreach (outside[i]) drive(outside[i], 0, 0);
    // R5: odd write in window
    bus_write('h200001, 3);
    chk_bank_now("R5 bank after odd write", 3);
    foreach (probe[i]) drive(probe[i], 0, 0);
    // R6: even and out-of-window writes are ignored
    bus_write('h200000, 1);
    chk_bank_now("R6 even write ignored", 3);
    bus_write('h000001, 0);
    chk_bank_now("R6 low-region write ignored", 3);
    bus_write('h100001, 2);
    chk_bank_now("R6 outside write ignored", 3);
    bus_write('h300001, 0);
    chk_bank_now("R6 upper write ignored", 3);
    drive('h2ABCDE, 0, 0);
    // R6: held strobe loads once
    drive('h2FFFFF, 0, 2);
    drive('h2FFFFF, 1, 2);
    drive('h2FFFFF, 1, 1);
    drive('h2FFFFF, 1, 0);
    drive('h2FFFFF, 1, 1);
    chk_bank_now("R6 held strobe single load", 2);
    drive('h2FFFFF, 0, 1);
    // R2: every bank value on the upper lines
    for (int b = 0; b < 4; b++) begin
      bus_write('h2FFFF1 - 2 * b, b);
      chk_bank_now("R2 bank value", b);
      drive('h2ABCDE, 0, 0);
      drive('h200000, 0, 0);
    end
    // R3 / R9: split map
    drive('h000000, 0, 0);
    lo_rom_16m = 1'b1;
    foreach (probe[i]) drive(probe[i], 0, 0);
    foreach (outside[i]) drive(outside[i], 0, 0);
    bus_write('h200003, 1);
    chk_bank_now("R9 bank loads in split map", 1);
    foreach (probe[i]) drive(probe[i], 0, 0);
    bus_write('h2FFFFF, 2);
    chk_bank_now("R9 second split-map load", 2);
    drive('h2ABCDE, 0, 0);
    drive('h0ABCDE, 0, 0);
    lo_rom_16m = 1'b0;
    drive('h2ABCDE, 0, 0);
    // R7: reset mid-run
    @(posedge clk); #3 rst_n = 1'b0;
    chk_bank_now("R7 bank cleared by reset", 0);
    @(posedge clk); #3 rst_n = 1'b1;
    drive('h2ABCDE, 0, 0);
    chk_bank_now("R7 bank stays 0 after reset", 0);
    drive('h000010, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule